// File: doc/BRIEF.md
# Readout Request Aggregator

This block sits on a shared command bus between a front-side readout controller and a row of digitizer modules. It relays the front-side clear, gate, write-acknowledge and readout-enable lines to the modules. It echoes the modules' write-strobe back to the front. It drives a test line whose level is set by software.

Every module raises its own request line when it has data. The block ORs these lines together. Because modules finish at slightly different times, the combined request is held back for a programmable number of clock cycles after the first line rises. A second copy of the combined request is also ANDed with an external enable input.

A small write port sets up the block. Address 0 bits 3:0 hold the request delay. Address 1 bit 0 sets the test level. Writing address 2 with bit 0 set issues a one-cycle clear. All asynchronous inputs pass through two-flop synchronizers.

Top module: `req_bus_hub`

## Requirements
- R1: `mod_clear_o` is high two clock edges after `fp_clear_i` rises. A write to address 2 with data bit 0 set raises it for exactly the one cycle after the write edge.
- R2: `mod_gate_o`, `mod_wack_o` and `mod_ren_o` copy `fp_gate_i`, `fp_wack_i` and `fp_ren_i` two clock edges after each input change.
- R3: `fp_wstb_o` copies `mod_wstb_i` two clock edges after each change.
- R4: `mod_test_o` holds bit 0 of the last write to address 1. It changes on no other write.
- R5: When the request lines go from all-low to any-high, `req_any_o` rises 3+D clock edges after the input change. D is the delay field, bits 3:0 written to address 0.
- R6: `req_any_o` stays low until the delay expires. It falls three edges after all request lines return low, and the next rise of the lines starts a fresh delay.
- R7: `req_gated_o` equals `req_any_o` ANDed with `req_en_i`, where the enable has two edges of synchronizer latency.
- R8: In any cycle where `mod_clear_o` is high, both request outputs are low. If request lines are still high after the clear, a new delay starts from the cycle after it.
- R9: Any single one of the NREQ request lines, including the highest-numbered one, is enough to trigger the combined request.
- R10: After reset, every output is low and the delay field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fp_clear_i | input | 1 | Front-side clear, asynchronous |
| fp_gate_i | input | 1 | Front-side gate, asynchronous |
| fp_wack_i | input | 1 | Front-side write-acknowledge, asynchronous |
| fp_ren_i | input | 1 | Front-side readout enable, asynchronous |
| req_en_i | input | 1 | Enable for the gated request, asynchronous |
| mod_req_i | input | NREQ | Per-module request lines, asynchronous |
| mod_wstb_i | input | 1 | Write-strobe from modules, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| mod_clear_o | output | 1 | Clear to modules |
| mod_gate_o | output | 1 | Gate to modules |
| mod_test_o | output | 1 | Test level to modules |
| mod_wack_o | output | 1 | Write-acknowledge to modules |
| mod_ren_o | output | 1 | Readout enable to modules |
| fp_wstb_o | output | 1 | Regenerated write-strobe to front |
| req_any_o | output | 1 | Delayed combined request |
| req_gated_o | output | 1 | Combined request ANDed with enable |

## Verification
The pass-through lines and the enable are due two edges after a change. The combined request is due at 3+D edges, and its fall is due three edges after the last line drops. A command clear shows in the cycle right after its write edge. The bench drives inputs on falling edges and samples 1 ns after the rising edge where a result is due. Around each delay boundary it checks both the edge before, where the output must still be low, and the edge where it is due.

// File: rtl/req_bus_hub.sv
module req_bus_hub #(
  parameter int NREQ  = 16,
  parameter int DLY_W = 4,
  parameter int AW    = 2,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_clear_i,
  input  logic            fp_gate_i,
  input  logic            fp_wack_i,
  input  logic            fp_ren_i,
  input  logic            req_en_i,
  input  logic [NREQ-1:0] mod_req_i,
  input  logic            mod_wstb_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic            mod_clear_o,
  output logic            mod_gate_o,
  output logic            mod_test_o,
  output logic            mod_wack_o,
  output logic            mod_ren_o,
  output logic            fp_wstb_o,
  output logic            req_any_o,
  output logic            req_gated_o
);
  localparam logic [AW-1:0] A_DLY  = AW'(0);
  localparam logic [AW-1:0] A_TEST = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam int NS = 6;

  logic [NS-1:0]   a_in, a_s1, a_s2;
  logic [NREQ-1:0] r_s1, r_s2;
  logic [DLY_W-1:0] dly_q, cnt_q;
  logic test_q, clr_cmd_q;
  logic req_or, req_or_q, rise, busy_q, rel_q;

  assign a_in = {fp_clear_i, fp_gate_i, fp_wack_i, fp_ren_i, mod_wstb_i, req_en_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_s1 <= '0; a_s2 <= '0; r_s1 <= '0; r_s2 <= '0;
    end else begin
      a_s1 <= a_in; a_s2 <= a_s1;
      r_s1 <= mod_req_i; r_s2 <= r_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly_q <= '0; test_q <= 1'b0; clr_cmd_q <= 1'b0;
    end else begin
      clr_cmd_q <= cfg_we_i && cfg_addr_i == A_CLR && cfg_wdata_i[0];
      if (cfg_we_i && cfg_addr_i == A_DLY)  dly_q  <= cfg_wdata_i[DLY_W-1:0];
      if (cfg_we_i && cfg_addr_i == A_TEST) test_q <= cfg_wdata_i[0];
    end

  assign mod_clear_o = a_s2[5] | clr_cmd_q;
  assign mod_gate_o  = a_s2[4];
  assign mod_wack_o  = a_s2[3];
  assign mod_ren_o   = a_s2[2];
  assign fp_wstb_o   = a_s2[1];
  assign mod_test_o  = test_q;

  assign req_or = |r_s2;
  assign rise   = req_or & ~req_or_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_or_q <= 1'b0; cnt_q <= '0; busy_q <= 1'b0; rel_q <= 1'b0;
    end else if (mod_clear_o) begin
      req_or_q <= 1'b0; cnt_q <= '0; busy_q <= 1'b0; rel_q <= 1'b0;
    end else begin
      req_or_q <= req_or;
      if (!req_or) begin
        cnt_q <= '0; busy_q <= 1'b0; rel_q <= 1'b0;
      end else if (rise) begin
        if (dly_q == '0) rel_q <= 1'b1;
        else begin cnt_q <= dly_q; busy_q <= 1'b1; end
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == DLY_W'(1)) begin busy_q <= 1'b0; rel_q <= 1'b1; end
      end
    end

  assign req_any_o   = rel_q & ~mod_clear_o;
  assign req_gated_o = req_any_o & a_s2[0];
endmodule

module req_bus_hub_chk #(
  parameter int NREQ = 16,
  parameter int AW   = 2,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] mod_req_i,
  input logic            cfg_we_i,
  input logic [AW-1:0]   cfg_addr_i,
  input logic [DW-1:0]   cfg_wdata_i,
  input logic            mod_clear_o,
  input logic            mod_test_o,
  input logic            req_any_o,
  input logic            req_gated_o
);
  p_gated_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_gated_o |-> req_any_o);
  p_clear_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clear_o |-> !req_any_o && !req_gated_o);
  p_any_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_any_o |-> $past(|mod_req_i, 3));
  p_test_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we_i && cfg_addr_i == AW'(1)) |=> $stable(mod_test_o));
  p_clear_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == AW'(2) && cfg_wdata_i[0]) |=> mod_clear_o);
endmodule

bind req_bus_hub req_bus_hub_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_req_i(mod_req_i), .cfg_we_i(cfg_we_i),
  .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .mod_clear_o(mod_clear_o),
  .mod_test_o(mod_test_o), .req_any_o(req_any_o), .req_gated_o(req_gated_o));

// File: tb/req_bus_hub_bench.sv
module req_bus_hub_bench;
  localparam int NREQ = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fp_clear_i = 0, fp_gate_i = 0, fp_wack_i = 0, fp_ren_i = 0, req_en_i = 0;
  logic [NREQ-1:0] mod_req_i = '0;
  logic mod_wstb_i = 0, cfg_we_i = 0;
  logic [1:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic mod_clear_o, mod_gate_o, mod_test_o, mod_wack_o, mod_ren_o, fp_wstb_o, req_any_o, req_gated_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  req_bus_hub #(.NREQ(NREQ)) u_req_bus_hub (.*);

  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b1000, 4'b0100, 4'b0010,
                                     4'b0001, 4'b1111, 4'b1010, 4'b0101};

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic drop_reqs();
    @(negedge clk); mod_req_i = '0; step(4);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    step(2);
    chk("R10 clear", mod_clear_o, 0); chk("R10 any", req_any_o, 0);
    chk("R10 gated", req_gated_o, 0); chk("R10 test", mod_test_o, 0);
    @(negedge clk); rst_n = 1;

    // R2 R3 vector walk: {gate, wack, ren, wstb}
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {fp_gate_i, fp_wack_i, fp_ren_i, mod_wstb_i} = VEC[i];
      step(1);
      chk("R2 gate early", mod_gate_o, VEC[(i+7)%8][3]);
      step(1);
      chk("R2 gate", mod_gate_o, VEC[i][3]); chk("R2 wack", mod_wack_o, VEC[i][2]);
      chk("R2 ren", mod_ren_o, VEC[i][1]); chk("R3 wstb", fp_wstb_o, VEC[i][0]);
    end

    // R4 test bit
    wr(2'd1, 8'h01); chk("R4 set", mod_test_o, 1);
    wr(2'd0, 8'h00); chk("R4 other addr", mod_test_o, 1);
    wr(2'd1, 8'h00); chk("R4 clr", mod_test_o, 0);

    // R5 D=0
    @(negedge clk); mod_req_i = 16'h0001;
    step(2); chk("R5 d0 early", req_any_o, 0);
    step(1); chk("R5 d0", req_any_o, 1);
    // R6 fall
    @(negedge clk); mod_req_i = '0;
    step(2); chk("R6 hold", req_any_o, 1);
    step(1); chk("R6 fall", req_any_o, 0);

    // R5 D=5, R9 top line
    wr(2'd0, 8'h05);
    @(negedge clk); mod_req_i = 16'h8000;
    step(7); chk("R5 d5 early", req_any_o, 0);
    step(1); chk("R9 d5 due", req_any_o, 1);
    drop_reqs();

    // R5 D=15, R6 restart on new rise
    wr(2'd0, 8'h0F);
    @(negedge clk); mod_req_i = 16'h0410;
    step(17); chk("R5 d15 early", req_any_o, 0);
    step(1); chk("R5 d15 due", req_any_o, 1);
    drop_reqs();
    @(negedge clk); mod_req_i = 16'h0002;
    step(17); chk("R6 restart early", req_any_o, 0);
    step(1); chk("R6 restart due", req_any_o, 1);

    // R7 enable gating
    chk("R7 off", req_gated_o, 0);
    @(negedge clk); req_en_i = 1;
    step(1); chk("R7 sync", req_gated_o, 0);
    step(1); chk("R7 on", req_gated_o, 1);

    // R8 + R1 command clear with requests held, D=0
    wr(2'd0, 8'h00);
    @(negedge clk); cfg_we_i = 1; cfg_addr_i = 2'd2; cfg_wdata_i = 8'h01;
    step(1);
    chk("R1 cmd", mod_clear_o, 1); chk("R8 any", req_any_o, 0); chk("R8 gated", req_gated_o, 0);
    @(negedge clk); cfg_we_i = 0;
    step(1); chk("R1 cmd pulse", mod_clear_o, 0); chk("R8 after", req_any_o, 0);
    step(1); chk("R8 restart", req_any_o, 1);

    // R1 front-panel clear
    @(negedge clk); fp_clear_i = 1;
    step(1); chk("R1 fp early", mod_clear_o, 0);
    step(1); chk("R1 fp", mod_clear_o, 1); chk("R8 fp any", req_any_o, 0);
    @(negedge clk); fp_clear_i = 0;
    step(2); chk("R1 fp off", mod_clear_o, 0);
    step(1); chk("R8 fp restart", req_any_o, 1);

    finish_run();
  end
endmodule